// File: doc/BRIEF.md
# Chained Fixed-Point Multiplier with Requantization

This block multiplies a stream of signed two's complement fixed-point operands together. Each operand comes with its own count of fractional bits, so operands in one chain may use different binary-point positions. The running result is always stored in one output format, set by parameters: `OUT_W` bits in total, of which `OUT_FRAC` are fractional.

The operand marked first does not go through the multiplier. It is converted to the output format and loaded as the running value. Each later operand is multiplied by the running value at full precision. That product has `OUT_W + IN_W` bits, and its fractional-bit count is `OUT_FRAC` plus the operand's own count. The product is then requantized to the output format before the next operand is taken in. Requantization shifts the product to the output binary point and drops the low bits with floor rounding. On overflow it either clamps or wraps, as chosen by a mode input that is sampled with each operand.

The result appears one cycle after the operand marked last is accepted. It comes with a valid pulse and an overflow flag that covers the whole chain. The block accepts one operand per clock cycle.

Top module: `fxp_chain_mul`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `res_valid_o` and `ovf_o` are 0 and `res_o` is 0. `ready_o` is 1 from the first clock edge after reset onward.
- R2: An operand accepted with `first_i`=1 is not multiplied. It is converted straight to the output format: shifted left when it has fewer fractional bits than `OUT_FRAC`, and requantized when it has more.
- R3: An operand accepted with `first_i`=0 is multiplied at full precision by the running value. The product has `OUT_FRAC + op_frac_i` fractional bits and is shifted right to `OUT_FRAC` fractional bits.
- R4: Dropped low bits are discarded with floor rounding, toward minus infinity. A small negative value therefore becomes -1 LSB, not 0.
- R5: `res_valid_o` is 1 for exactly one cycle, the cycle after an operand with `last_i`=1 is accepted, and is 0 at all other times. `res_o` changes only on an accepted operand.
- R6: With `sat_mode_i`=1, a converted value outside the signed `OUT_W` range becomes the largest or the smallest representable value, following the sign of the true value.
- R7: With `sat_mode_i`=0, a converted value outside the range keeps only its low `OUT_W` bits.
- R8: `ovf_o` is set if any conversion in the chain overflowed. It stays set through the rest of the chain and is cleared or set anew by the conversion of the next operand marked first.
- R9: A cycle with `valid_i`=0 leaves the running value and the overflow state unchanged, whatever the other inputs hold.
- R10: Each converted result becomes a factor of the next multiplication. With the default parameters, 5.75 (2 fractional bits), then 2.375 (3), then 1.8125 (4) gives 395, which is 24.6875.
- R11: An operand marked both first and last gives the converted operand alone as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present |
| ready_o | output | 1 | Block can accept an operand |
| op_i | input | IN_W | Signed operand word |
| op_frac_i | input | FC_W | Number of fractional bits of `op_i` |
| first_i | input | 1 | Operand starts a new chain |
| last_i | input | 1 | Operand ends the chain |
| sat_mode_i | input | 1 | 1: clamp on overflow, 0: wrap |
| res_o | output | OUT_W | Running or final product in the output format |
| res_valid_o | output | 1 | `res_o` holds a finished chain result |
| ovf_o | output | 1 | Some conversion in the chain overflowed |

## Verification
The hardest case to reach is an overflow in the middle of a chain followed by later operands that bring the value back into range. The final word is then in range, but the overflow flag must still be set, and in wrap mode the wrapped intermediate value must feed the following multiplications. Random chains with full-range operands and few fractional bits make overflow in the middle of a chain common. Directed chains start with a word at the range limit and then multiply by small factors. A negative operand with many fractional bits drives the floor rounding to -1 LSB.

// File: rtl/fxp_chain_pkg.sv
package fxp_chain_pkg;
  typedef enum logic {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;
endpackage

// File: rtl/fxp_mul_sel.sv
// Selects the raw value and its binary point: bypass for a first operand,
// full-precision product otherwise.
module fxp_mul_sel #(
  parameter int IN_W     = 8,
  parameter int FC_W     = 4,
  parameter int OUT_W    = 10,
  parameter int OUT_FRAC = 4,
  localparam int PROD_W  = OUT_W + IN_W,
  localparam int RF_W    = $clog2(OUT_FRAC + (1 << FC_W))
) (
  input  logic signed [OUT_W-1:0]  acc_i,
  input  logic signed [IN_W-1:0]   op_i,
  input  logic        [FC_W-1:0]   op_frac_i,
  input  logic                     first_i,
  output logic signed [PROD_W-1:0] raw_o,
  output logic        [RF_W-1:0]   raw_frac_o
);
  always_comb begin
    if (first_i) begin
      raw_o      = PROD_W'(op_i);
      raw_frac_o = RF_W'(op_frac_i);
    end else begin
      raw_o      = PROD_W'(acc_i) * PROD_W'(op_i);
      raw_frac_o = RF_W'(OUT_FRAC) + RF_W'(op_frac_i);
    end
  end
endmodule

// File: rtl/fxp_requant.sv
// Aligns a raw value to the output binary point, floors, then clamps or wraps.
module fxp_requant
  import fxp_chain_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int FC_W     = 4,
  parameter int OUT_W    = 10,
  parameter int OUT_FRAC = 4,
  localparam int PROD_W  = OUT_W + IN_W,
  localparam int RF_W    = $clog2(OUT_FRAC + (1 << FC_W)),
  localparam int EXT_W   = PROD_W + OUT_FRAC + 1
) (
  input  logic signed [PROD_W-1:0] raw_i,
  input  logic        [RF_W-1:0]   raw_frac_i,
  input  logic                     sat_i,
  output logic signed [OUT_W-1:0]  res_o,
  output logic                     ovf_o
);
  localparam logic [RF_W-1:0] OF_R = RF_W'(OUT_FRAC);
  localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [EXT_W-1:0] ext, aligned;
  logic        [EXT_W-OUT_W:0] upper;
  ovf_mode_e mode;

  assign mode = ovf_mode_e'(sat_i);
  assign ext  = EXT_W'(raw_i);

  always_comb begin
    if (raw_frac_i >= OF_R) aligned = ext >>> (raw_frac_i - OF_R);  // floor
    else                    aligned = ext <<< (OF_R - raw_frac_i);
  end

  assign upper = aligned[EXT_W-1:OUT_W-1];
  assign ovf_o = !((&upper) || (~|upper));

  always_comb begin
    res_o = aligned[OUT_W-1:0];
    if (ovf_o && mode == OVF_SAT) res_o = aligned[EXT_W-1] ? MIN_V : MAX_V;
  end
endmodule

// File: rtl/fxp_chain_ctrl.sv
// Running value, sticky overflow and result strobe.
module fxp_chain_ctrl #(
  parameter int OUT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic signed [OUT_W-1:0] conv_i,
  input  logic                    conv_ovf_i,
  output logic signed [OUT_W-1:0] acc_o,
  output logic                    ovf_o,
  output logic                    vld_o,
  output logic                    rdy_o
);
  logic signed [OUT_W-1:0] acc_q;
  logic ovf_q, vld_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= take_i && last_i;
      if (take_i) begin
        acc_q <= conv_i;
        ovf_q <= first_i ? conv_ovf_i : (ovf_q | conv_ovf_i);
      end
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
  assign vld_o = vld_q;
  assign rdy_o = rdy_q;

  a_r5_valid_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && last_i) |=> vld_o);
  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_i && last_i) |=> !vld_o);
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(acc_o) && $stable(ovf_o)));
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !first_i && ovf_o) |=> ovf_o);
  a_r8_ovf_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && first_i && !conv_ovf_i) |=> !ovf_o);
endmodule

// File: rtl/fxp_chain_mul.sv
module fxp_chain_mul
  import fxp_chain_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int FC_W     = 4,
  parameter int OUT_W    = 10,
  parameter int OUT_FRAC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  output logic                    ready_o,
  input  logic signed [IN_W-1:0]  op_i,
  input  logic        [FC_W-1:0]  op_frac_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic                    sat_mode_i,
  output logic signed [OUT_W-1:0] res_o,
  output logic                    res_valid_o,
  output logic                    ovf_o
);
  localparam int PROD_W = OUT_W + IN_W;
  localparam int RF_W   = $clog2(OUT_FRAC + (1 << FC_W));
  localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] raw;
  logic        [RF_W-1:0]   raw_frac;
  logic signed [OUT_W-1:0]  conv, acc;
  logic                     conv_ovf, take;

  assign take = valid_i && ready_o;

  fxp_mul_sel #(.IN_W(IN_W), .FC_W(FC_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_sel (
    .acc_i(acc), .op_i(op_i), .op_frac_i(op_frac_i), .first_i(first_i),
    .raw_o(raw), .raw_frac_o(raw_frac)
  );

  fxp_requant #(.IN_W(IN_W), .FC_W(FC_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) u_rq (
    .raw_i(raw), .raw_frac_i(raw_frac), .sat_i(sat_mode_i),
    .res_o(conv), .ovf_o(conv_ovf)
  );

  fxp_chain_ctrl #(.OUT_W(OUT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .first_i(first_i), .last_i(last_i),
    .conv_i(conv), .conv_ovf_i(conv_ovf),
    .acc_o(acc), .ovf_o(ovf_o), .vld_o(res_valid_o), .rdy_o(ready_o)
  );

  assign res_o = acc;

  a_r6_sat_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && sat_mode_i && conv_ovf) |=> (res_o == MAX_V || res_o == MIN_V));
  a_r4_floor_keeps_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !conv_ovf && raw < 0) |=> (res_o < 0));
  a_r8_ovf_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && conv_ovf) |=> ovf_o);
endmodule

// File: tb/fxp_chain_mul_test.sv
module fxp_chain_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8, FC_W = 4, OUT_W = 10, OUT_FRAC = 4;
  localparam longint MAXV = (64'sd1 <<< (OUT_W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (OUT_W-1));

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, first_i = 1'b0, last_i = 1'b0, sat_mode_i = 1'b0;
  logic signed [IN_W-1:0] op_i = '0;
  logic [FC_W-1:0] op_frac_i = '0;
  logic ready_o, res_valid_o, ovf_o;
  logic signed [OUT_W-1:0] res_o;

  int n_run = 0, n_fail = 0;
  longint m_acc = 0;
  bit m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_chain_mul #(.IN_W(IN_W), .FC_W(FC_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .op_i(op_i), .op_frac_i(op_frac_i), .first_i(first_i), .last_i(last_i),
    .sat_mode_i(sat_mode_i), .res_o(res_o), .res_valid_o(res_valid_o), .ovf_o(ovf_o)
  );

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_step(longint op, int frac, bit first, bit sat);
    longint raw, v;
    int rf;
    bit ov;
    if (first) begin raw = op; rf = frac; end
    else begin raw = m_acc * op; rf = OUT_FRAC + frac; end
    if (rf >= OUT_FRAC) v = raw >>> (rf - OUT_FRAC);
    else v = raw <<< (OUT_FRAC - rf);
    ov = (v > MAXV) || (v < MINV);
    if (ov) begin
      if (sat) v = (v > MAXV) ? MAXV : MINV;
      else begin
        v = v & ((64'sd1 <<< OUT_W) - 1);
        if (v > MAXV) v = v - (64'sd1 <<< OUT_W);
      end
    end
    m_acc = v;
    m_ovf = first ? ov : (m_ovf | ov);
  endfunction

  task automatic send(logic signed [IN_W-1:0] op, int frac, bit first, bit last, bit sat);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; op_frac_i = FC_W'(frac);
    first_i = first; last_i = last; sat_mode_i = sat;
    model_step(longint'(op), frac, first, sat);
  endtask

  // Idle cycles with junk on every other input (R9)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; op_i = IN_W'($urandom); op_frac_i = FC_W'($urandom);
      first_i = 1'($urandom); last_i = 1'($urandom); sat_mode_i = 1'($urandom);
      if (i > 0) check("R5 no valid while idle", longint'(res_valid_o), 0);
    end
  endtask

  task automatic close_chain(string req);
    @(negedge clk);
    valid_i = 1'b0; first_i = 1'b0; last_i = 1'b0;
    check({req, " valid"}, longint'(res_valid_o), 1);
    check({req, " result"}, longint'(res_o), m_acc);
    check({req, " ovf"}, longint'(ovf_o), longint'(m_ovf));
    @(negedge clk);
    check("R5 valid one cycle", longint'(res_valid_o), 0);
    check("R5 result held", longint'(res_o), m_acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2);
    check("R1 valid in reset", longint'(res_valid_o), 0);
    check("R1 ready in reset", longint'(ready_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", longint'(res_valid_o), 0);
    check("R1 ovf after reset", longint'(ovf_o), 0);
    check("R1 res after reset", longint'(res_o), 0);
    check("R1 ready after reset", longint'(ready_o), 1);

    // R10 reference chain: 5.75, 2.375, 1.8125 -> 395
    send(8'sd23, 2, 1, 0, 1);
    send(8'sd19, 3, 0, 0, 1);
    send(8'sd29, 4, 0, 1, 1);
    close_chain("R10 reference chain");
    check("R10 fixed value", longint'(res_o), 395);

    // R3 two-step partial: 92*19 floor >>3 = 218
    send(8'sd23, 2, 1, 0, 0);
    send(8'sd19, 3, 0, 1, 0);
    close_chain("R3 product requant");
    check("R3 fixed value", longint'(res_o), 218);

    // R2/R11 first with fewer frac bits -> left shift: 3 (frac 0) -> 48
    send(8'sd3, 0, 1, 1, 0);
    close_chain("R11 single operand");
    check("R2 left shift", longint'(res_o), 48);

    // R4 floor: -1 with 7 frac bits -> -1 LSB
    send(-8'sd1, 7, 1, 1, 0);
    close_chain("R4 floor negative");
    check("R4 fixed value", longint'(res_o), -1);

    // R6 saturate high and low
    send(8'sd127, 0, 1, 1, 1);
    close_chain("R6 sat high");
    check("R6 fixed max", longint'(res_o), 511);
    send(-8'sd128, 0, 1, 1, 1);
    close_chain("R6 sat low");
    check("R6 fixed min", longint'(res_o), -512);

    // R7 wrap: 2032 -> -16
    send(8'sd127, 0, 1, 1, 0);
    close_chain("R7 wrap");
    check("R7 fixed wrap", longint'(res_o), -16);

    // R8 overflow early, final value in range, flag stays
    send(8'sd127, 0, 1, 0, 1);
    send(8'sd1, 7, 0, 1, 1);
    close_chain("R8 sticky");
    check("R8 fixed flag", longint'(ovf_o), 1);
    send(8'sd1, 0, 1, 1, 1);
    close_chain("R8 cleared by first");
    check("R8 fixed clear", longint'(ovf_o), 0);

    // R9 gaps inside a chain
    send(8'sd40, 3, 1, 0, 0);
    idle(3);
    send(-8'sd12, 2, 0, 0, 0);
    idle(2);
    send(8'sd9, 1, 0, 1, 0);
    close_chain("R9 idle ignored");

    // Random chains
    for (int c = 0; c < 300; c++) begin
      int len;
      len = 1 + int'($urandom_range(3));
      for (int k = 0; k < len; k++) begin
        send(IN_W'($urandom), int'($urandom_range(15)), k == 0, k == len-1,
             1'($urandom));
        if ($urandom_range(3) == 0 && k != len-1) idle(1 + int'($urandom_range(2)));
      end
      close_chain("R3 R6 R7 R8 random chain");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule